// File: doc/BRIEF.md
# High-Speed Mode Entry/Exit Tracker

This block is a passive monitor for a two-wire serial bus. It watches the data and clock lines, recognises bus start, repeated-start and stop conditions, and captures the first byte that follows a start. When that byte carries the high-speed master-code pattern and the ninth clock carries a not-acknowledge, the block reports that the bus has moved to high-speed mode. It keeps reporting high-speed mode across any number of repeated starts, and it drops back to the normal (fast/standard) mode only when a stop condition appears.

Any device that must change its own timing when the bus changes speed uses the level flag to select its settings. It uses the single-cycle entry and exit pulses to start those changes. The captured 3-bit master identifier says which master won the bus, and a separate flag marks the code reserved for test use. The line inputs are taken to be already synchronised and deglitched into the block's clock domain.

Top module: `hs_mode_tracker`

## Requirements
- R1: After reset, hsActive, masterId, testCode, enterPulse and exitPulse are all 0.
- R2: A start (SDA falling while SCL is high), then eight bits sampled MSB first on SCL rising edges whose upper five bits are 00001, then a ninth bit sampled high (not-acknowledge) sets hsActive. The flag is visible from the clock cycle after the clock edge that sees that ninth SCL rise.
- R3: On entry, masterId takes the low three bits of the captured byte. It holds that value for as long as hsActive stays high.
- R4: testCode is high exactly while hsActive is high and masterId is 000.
- R5: A first byte whose upper five bits differ from 00001 leaves hsActive low. This includes the reserved pattern 00000xxx.
- R6: A matching byte followed by a ninth bit sampled low (acknowledge) leaves hsActive low.
- R7: While hsActive is high, repeated starts and the bytes that follow them keep hsActive high and leave masterId unchanged. This holds even when such a byte is itself a master code.
- R8: A stop (SDA rising while SCL is high) in high-speed mode clears hsActive and gives one exitPulse. A stop outside high-speed mode gives no exitPulse.
- R9: enterPulse and exitPulse are each high for exactly one cycle per transition, and enterPulse occurs only once per entry.
- R10: A stop seen during the first byte abandons the capture. A start seen during the first byte restarts the capture with a fresh byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdaIn | input | 1 | Synchronised data line level |
| sclIn | input | 1 | Synchronised clock line level |
| hsActive | output | 1 | High while the bus is in high-speed mode |
| masterId | output | 3 | Identifier from the low bits of the last accepted master code |
| testCode | output | 1 | High while in high-speed mode under the reserved test code |
| enterPulse | output | 1 | One-cycle pulse on entry to high-speed mode |
| exitPulse | output | 1 | One-cycle pulse on return to normal mode |

## Verification
The stimulus mixes random first bytes, about half of which are forced to carry the master-code prefix and some forced to the 00000xxx reserved pattern, with random acknowledge and not-acknowledge ninth bits. These separate a real entry from a near-miss on the byte and from a near-miss on the ninth bit. Random chained repeated starts, some carrying a second master code, show that the mode and identifier survive repeated starts. Stops both after entry and after rejected sequences show that exit pulses come only from real high-speed sessions. Directed cases cover the test code and a capture cut short by a stop or a start, which show whether the byte capture truly restarts.

// File: rtl/hsmon_pkg.sv
package hsmon_pkg;
  localparam int CODE_BITS   = 8;
  localparam int ID_BITS     = 3;
  localparam int PREFIX_BITS = CODE_BITS - ID_BITS;
  localparam int CNT_W       = $clog2(CODE_BITS + 1);
  localparam logic [PREFIX_BITS-1:0] HS_PREFIX = PREFIX_BITS'(1);

  // strobes from control to datapath
  typedef struct packed {
    logic clearByte;
    logic shiftBit;
    logic latchId;
  } dpCmd_t;

  // conditions from datapath to control
  typedef struct packed {
    logic startSeen;
    logic stopSeen;
    logic sclRise;
    logic sdaBit;
    logic byteFull;
    logic codeHit;
  } busEv_t;

  typedef enum logic [1:0] {
    ST_FS   = 2'd0,
    ST_CODE = 2'd1,
    ST_ACK  = 2'd2,
    ST_HS   = 2'd3
  } mode_e;
endpackage

// File: rtl/hsmon_dp.sv
module hsmon_dp
  import hsmon_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sdaIn,
  input  logic               sclIn,
  input  dpCmd_t             cmd,
  output busEv_t             ev,
  output logic [ID_BITS-1:0] masterId
);
  logic                 sdaQ, sclQ;
  logic [CODE_BITS-1:0] shReg;
  logic [CNT_W-1:0]     bitCnt;

  // previous line levels, idle bus is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdaQ <= 1'b1;
      sclQ <= 1'b1;
    end else begin
      sdaQ <= sdaIn;
      sclQ <= sclIn;
    end
  end

  always_comb begin
    ev.startSeen = sclQ & sclIn & sdaQ & ~sdaIn;
    ev.stopSeen  = sclQ & sclIn & ~sdaQ & sdaIn;
    ev.sclRise   = ~sclQ & sclIn;
    ev.sdaBit    = sdaIn;
    ev.byteFull  = (bitCnt == CNT_W'(CODE_BITS));
    ev.codeHit   = (shReg[CODE_BITS-1:ID_BITS] == HS_PREFIX);
  end

  // first-byte shifter, MSB first
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shReg  <= '0;
      bitCnt <= '0;
    end else if (cmd.clearByte) begin
      shReg  <= '0;
      bitCnt <= '0;
    end else if (cmd.shiftBit && !ev.byteFull) begin
      shReg  <= {shReg[CODE_BITS-2:0], sdaIn};
      bitCnt <= bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           masterId <= '0;
    else if (cmd.latchId) masterId <= shReg[ID_BITS-1:0];
  end
endmodule

// File: rtl/hsmon_ctrl.sv
module hsmon_ctrl
  import hsmon_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  busEv_t ev,
  output dpCmd_t cmd,
  output logic   hsActive,
  output logic   enterPulse,
  output logic   exitPulse
);
  mode_e state, stateNext;
  logic  enterNext, exitNext;

  always_comb begin
    stateNext = state;
    cmd       = '0;
    enterNext = 1'b0;
    exitNext  = 1'b0;
    unique case (state)
      ST_FS: begin
        if (ev.startSeen) begin
          cmd.clearByte = 1'b1;
          stateNext     = ST_CODE;
        end
      end
      ST_CODE: begin
        if (ev.startSeen) begin
          cmd.clearByte = 1'b1;
        end else if (ev.stopSeen) begin
          stateNext = ST_FS;
        end else if (ev.byteFull) begin
          stateNext = ev.codeHit ? ST_ACK : ST_FS;
        end else if (ev.sclRise) begin
          cmd.shiftBit = 1'b1;
        end
      end
      ST_ACK: begin
        if (ev.startSeen) begin
          cmd.clearByte = 1'b1;
          stateNext     = ST_CODE;
        end else if (ev.stopSeen) begin
          stateNext = ST_FS;
        end else if (ev.sclRise) begin
          if (ev.sdaBit) begin
            cmd.latchId = 1'b1;
            enterNext   = 1'b1;
            stateNext   = ST_HS;
          end else begin
            stateNext = ST_FS;
          end
        end
      end
      ST_HS: begin
        if (ev.stopSeen) begin
          exitNext  = 1'b1;
          stateNext = ST_FS;
        end
      end
      default: stateNext = ST_FS;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_FS;
      enterPulse <= 1'b0;
      exitPulse  <= 1'b0;
    end else begin
      state      <= stateNext;
      enterPulse <= enterNext;
      exitPulse  <= exitNext;
    end
  end

  assign hsActive = (state == ST_HS);
endmodule

// File: rtl/hs_mode_tracker.sv
module hs_mode_tracker
  import hsmon_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sdaIn,
  input  logic               sclIn,
  output logic               hsActive,
  output logic [ID_BITS-1:0] masterId,
  output logic               testCode,
  output logic               enterPulse,
  output logic               exitPulse
);
  dpCmd_t cmd;
  busEv_t ev;

  hsmon_dp u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .sdaIn    (sdaIn),
    .sclIn    (sclIn),
    .cmd      (cmd),
    .ev       (ev),
    .masterId (masterId)
  );

  hsmon_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev         (ev),
    .cmd        (cmd),
    .hsActive   (hsActive),
    .enterPulse (enterPulse),
    .exitPulse  (exitPulse)
  );

  assign testCode = hsActive && (masterId == '0);
endmodule

// File: rtl/hsmon_checker.sv
module hsmon_checker
  import hsmon_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               sdaIn,
  input logic               sclIn,
  input logic               hsActive,
  input logic [ID_BITS-1:0] masterId,
  input logic               testCode,
  input logic               enterPulse,
  input logic               exitPulse
);
  logic prevSda, prevScl, startEv, stopEv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevSda <= 1'b1;
      prevScl <= 1'b1;
    end else begin
      prevSda <= sdaIn;
      prevScl <= sclIn;
    end
  end

  assign startEv = prevScl && sclIn && prevSda && !sdaIn;
  assign stopEv  = prevScl && sclIn && !prevSda && sdaIn;

  // R2: entry only follows a sampled high ninth bit on a high clock line
  a_r2_entry_on_nack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsActive) |-> ($past(sdaIn) && $past(sclIn) && enterPulse));

  // R3: identifier frozen while in high-speed mode
  a_r3_id_held: assert property (@(posedge clk) disable iff (!rst_n)
    (hsActive && $past(hsActive)) |-> $stable(masterId));

  // R4: test flag only inside high-speed mode
  a_r4_test_in_hs: assert property (@(posedge clk) disable iff (!rst_n)
    testCode |-> hsActive);

  // R7: repeated start keeps the mode
  a_r7_sr_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (hsActive && startEv) |=> hsActive);

  // R8: stop leaves the mode with an exit pulse
  a_r8_stop_exits: assert property (@(posedge clk) disable iff (!rst_n)
    (hsActive && stopEv) |=> (!hsActive && exitPulse));

  // R9: pulses last one cycle
  a_r9_enter_one: assert property (@(posedge clk) disable iff (!rst_n)
    enterPulse |=> !enterPulse);
  a_r9_exit_one: assert property (@(posedge clk) disable iff (!rst_n)
    exitPulse |=> !exitPulse);
  a_r9_exit_low: assert property (@(posedge clk) disable iff (!rst_n)
    exitPulse |-> !hsActive);
endmodule

bind hs_mode_tracker hsmon_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sdaIn      (sdaIn),
  .sclIn      (sclIn),
  .hsActive   (hsActive),
  .masterId   (masterId),
  .testCode   (testCode),
  .enterPulse (enterPulse),
  .exitPulse  (exitPulse)
);

// File: tb/tb_hs_mode_tracker.sv
module tb_hs_mode_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD       = 2;
  localparam int WATCHDOG   = 150000;
  localparam int ITERS      = 60;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sdaIn = 1'b1;
  logic       sclIn = 1'b1;
  logic       hsActive, testCode, enterPulse, exitPulse;
  logic [2:0] masterId;

  int nChecks = 0;
  int nFail   = 0;
  int enterCnt = 0, exitCnt = 0, pulseErr = 0;
  logic prevEnter = 1'b0, prevExit = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hs_mode_tracker dut (
    .clk(clk), .rst_n(rst_n), .sdaIn(sdaIn), .sclIn(sclIn),
    .hsActive(hsActive), .masterId(masterId), .testCode(testCode),
    .enterPulse(enterPulse), .exitPulse(exitPulse)
  );

  // pulse monitor at the ports
  always @(negedge clk) begin
    if (rst_n) begin
      if (enterPulse) enterCnt++;
      if (exitPulse)  exitCnt++;
      if (enterPulse && prevEnter) pulseErr++;
      if (exitPulse && prevExit)   pulseErr++;
      prevEnter = enterPulse;
      prevExit  = exitPulse;
    end
  end

  function automatic bit expEnter(input logic [7:0] code, input bit nack);
    return (code[7:3] == 5'b00001) && nack;
  endfunction

  function automatic bit expTest(input logic [7:0] code);
    return code[2:0] == 3'b000;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendStart();
    sdaIn = 1'b1; waitClk(HOLD);
    sclIn = 1'b1; waitClk(HOLD);
    sdaIn = 1'b0; waitClk(HOLD);
    sclIn = 1'b0; waitClk(HOLD);
  endtask

  task automatic sendBit(input bit b);
    sdaIn = b;    waitClk(HOLD);
    sclIn = 1'b1; waitClk(HOLD);
    sclIn = 1'b0; waitClk(HOLD);
  endtask

  task automatic sendByte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
  endtask

  task automatic sendStop();
    sdaIn = 1'b0; waitClk(HOLD);
    sclIn = 1'b1; waitClk(HOLD);
    sdaIn = 1'b1; waitClk(HOLD);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    int e0, x0;
    logic [7:0] code, code2;
    bit nack, exp;
    void'($urandom(32'd20240611));

    waitClk(3);
    rst_n = 1'b1;
    waitClk(2);
    // R1 reset state
    check(hsActive == 0,   "R1 hsActive", hsActive, 0);
    check(masterId == 0,   "R1 masterId", masterId, 0);
    check(testCode == 0,   "R1 testCode", testCode, 0);
    check(!enterPulse && !exitPulse, "R1 pulses", {enterPulse, exitPulse}, 0);

    // R4 directed: reserved test code enters with testCode set
    e0 = enterCnt;
    sendStart(); sendByte(8'b0000_1000); sendBit(1'b1); waitClk(1);
    check(hsActive == 1, "R2 test-code entry", hsActive, 1);
    check(testCode == 1, "R4 testCode high", testCode, 1);
    check(enterCnt == e0 + 1, "R9 one enter pulse", enterCnt, e0 + 1);
    x0 = exitCnt;
    sendStop(); waitClk(1);
    check(hsActive == 0, "R8 stop exits", hsActive, 0);
    check(testCode == 0, "R4 testCode low after stop", testCode, 0);
    check(exitCnt == x0 + 1, "R8 exit pulse", exitCnt, x0 + 1);

    // R10 directed: stop in mid-byte abandons capture
    e0 = enterCnt;
    sendStart(); sendBit(1'b0); sendBit(1'b0); sendBit(1'b0);
    sendStop();
    sendBit(1'b0); sendBit(1'b1); sendBit(1'b1); sendBit(1'b1);
    sendBit(1'b0); sendBit(1'b1); waitClk(1);
    check(hsActive == 0, "R10 stop aborts capture", hsActive, 0);
    check(enterCnt == e0, "R10 no entry after abort", enterCnt, e0);

    // R10 directed: start in mid-byte restarts capture
    sendStart(); sendBit(1'b1); sendBit(1'b1);
    sendStart(); sendByte(8'b0000_1101); sendBit(1'b1); waitClk(1);
    check(hsActive == 1, "R10 restart then entry", hsActive, 1);
    check(masterId == 3'd5, "R10 fresh byte id", masterId, 5);
    sendStop(); waitClk(1);

    // random mix
    for (int it = 0; it < ITERS; it++) begin
      code = 8'($urandom);
      if ($urandom % 2) code[7:3] = 5'b00001;
      else if ($urandom % 3 == 0) code[7:3] = 5'b00000;
      nack = ($urandom % 4) != 0;
      exp  = expEnter(code, nack);
      e0 = enterCnt; x0 = exitCnt;

      sendStart(); sendByte(code); sendBit(nack); waitClk(1);
      if (exp) begin
        check(hsActive == 1, "R2 entry", hsActive, 1);
        check(masterId == code[2:0], "R3 id captured", masterId, code[2:0]);
        check(testCode == expTest(code), "R4 testCode", testCode, expTest(code));
        check(enterCnt == e0 + 1, "R9 enter count", enterCnt, e0 + 1);
      end else if (code[7:3] == 5'b00001) begin
        check(hsActive == 0, "R6 ack rejects", hsActive, 0);
        check(enterCnt == e0, "R6 no pulse", enterCnt, e0);
      end else begin
        check(hsActive == 0, "R5 byte rejects", hsActive, 0);
        check(enterCnt == e0, "R5 no pulse", enterCnt, e0);
      end

      if ($urandom % 2) begin
        code2 = 8'($urandom);
        if (!exp) code2[7] = 1'b1;
        else if ($urandom % 2) code2[7:3] = 5'b00001;
        sendStart(); sendByte(code2); sendBit(1'($urandom)); waitClk(1);
        check(hsActive == exp, "R7 mode after repeated start", hsActive, exp);
        if (exp) begin
          check(masterId == code[2:0], "R7 id unchanged", masterId, code[2:0]);
          check(enterCnt == e0 + 1, "R7 no new enter", enterCnt, e0 + 1);
        end
      end

      sendStop(); waitClk(1);
      check(hsActive == 0, "R8 idle after stop", hsActive, 0);
      check(exitCnt == x0 + int'(exp), "R8 exit count", exitCnt, x0 + int'(exp));
    end

    check(pulseErr == 0, "R9 pulse width", pulseErr, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule